// File: doc/BRIEF.md
# In-Order Pipeline Stall and Flush Controller

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) may advance. The pipeline has no forwarding paths and no branch prediction. The datapath gives the block the decoded fields of the instruction in decode and the destination fields of the two older instructions in execute and memory. The block returns four controls. A stall holds the program counter and the fetch/decode latch. A flush turns the fetch/decode latch into a no-op. A bubble loads a no-op into the decode/execute latch. The last control picks the branch target as the next fetch address.

A decode-stage instruction that reads a register still waiting to be written by execute or memory is held in decode. Bubbles flow down the pipe until the producer reaches write-back. The register file writes before it reads within a cycle, so a producer in write-back never holds anything up. A multiply writes a register pair, rd and rd+1, and both are treated as pending.

When decode holds a branch, fetch is frozen and the instruction fetched behind the branch is discarded. The branch reaches execute and is resolved there. If it is taken, the next fetch comes from the target. If it is not taken, the frozen sequential address is fetched again.

All outputs are combinational functions of the current inputs. The reset input only forces them low.

Top module: `hz_ctrl`

## Requirements
- R1: While rst_n is low, stall, pc_hold, ifid_flush, idex_bubble and pc_target are all 0.
- R2: A valid decode instruction whose used source register matches a pending destination in execute or memory raises stall, pc_hold and idex_bubble, with ifid_flush and pc_target low.
- R3: When no pending destination in execute or memory matches a used source, nothing is stalled. A producer that has already left memory is not an input and causes no stall.
- R4: Register 0 is never pending. A source or destination of 0 never causes a stall.
- R5: A producer with its multiply flag set marks rd and rd+1 modulo 32 as pending. For rd=31 that is only register 31, since register 0 is excluded.
- R6: The class code id_class selects the sources that are compared. 0 means none. 1 (two-register ALU), 4 (store), 5 (branch) and 7 (multiply) compare id_rs and id_rt. 2 (immediate ALU) and 3 (load) compare id_rs only. 6 (shift) compares id_rt only.
- R7: A valid branch (class 5) in decode with no hazard and no redirect raises pc_hold and ifid_flush, with stall, idex_bubble and pc_target low.
- R8: A branch in decode that has a data hazard is stalled as in R2 and is not flushed.
- R9: A taken branch in execute (ex_valid, ex_branch and ex_taken all high) raises pc_target, ifid_flush and idex_bubble, and holds stall and pc_hold low, whatever decode holds.
- R10: A not-taken branch in execute does not redirect. The decode stage is judged as in R2 to R7.
- R11: A producer with its valid or write-enable low creates no pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the checks |
| rst_n | input | 1 | Synchronous active-low reset; forces all controls low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_class | input | 3 | Decode instruction class code (see R6) |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes the register file |
| ex_pair | input | 1 | Execute instruction is a multiply writing rd and rd+1 |
| ex_rd | input | 5 | Execute destination register |
| ex_branch | input | 1 | Execute instruction is a branch |
| ex_taken | input | 1 | Branch condition evaluated in execute is true |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory instruction writes the register file |
| mem_pair | input | 1 | Memory instruction is a multiply writing rd and rd+1 |
| mem_rd | input | 5 | Memory destination register |
| stall | output | 1 | Hold the fetch/decode latch (data hazard) |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_flush | output | 1 | Replace the fetch/decode latch with a no-op |
| idex_bubble | output | 1 | Load a no-op into the decode/execute latch |
| pc_target | output | 1 | Next PC is the branch target from execute |

## Verification
Directed patterns place one matching producer in execute and then in memory. The decode class changes while the registers stay the same. This separates a missing source-select decode from a missing stage compare. Pair writes at rd=8 and rd=31, and register 0 on either side, show whether the rd+1 wrap and the zero exclusion are right. Branches are tried in decode with and without a hazard and in execute taken and not taken, which shows which control wins. A long stream of pseudo-random fields is then compared each cycle against a reference model built from integers.

// File: rtl/hz_pkg.sv
// Package: shared types for the pipeline hazard controller.
// Assumes a register file of 2**REG_W entries with entry 0 hardwired to zero.
package hz_pkg;

    // Decode-stage instruction class; selects which sources are compared.
    typedef enum logic [2:0] {
        CL_NONE   = 3'd0,  // no register source (nop, lui)
        CL_REG2   = 3'd1,  // two-register ALU
        CL_IMM    = 3'd2,  // immediate ALU, reads rs
        CL_LOAD   = 3'd3,  // load, reads base rs
        CL_STORE  = 3'd4,  // store, reads base rs and data rt
        CL_BRANCH = 3'd5,  // compare branch, reads rs and rt
        CL_SHIFT  = 3'd6,  // shift by amount, reads rt
        CL_MUL    = 3'd7   // multiply, reads rs and rt
    } iclass_e;

    // Bundle of the pipeline control outputs.
    typedef struct packed {
        logic stall;
        logic pc_hold;
        logic ifid_flush;
        logic idex_bubble;
        logic pc_target;
    } ctl_t;

endpackage

// File: rtl/hz_src_decode.sv
// Module: hz_src_decode
// Turns the decode-stage class code into "source A used", "source B used"
// and "is a branch" flags. Assumes an invalid slot uses no sources.
module hz_src_decode
    import hz_pkg::*;
(
    input  logic    valid,
    input  iclass_e cls,
    output logic    use_a,
    output logic    use_b,
    output logic    is_branch
);

    // Source-use table per class.
    always_comb begin
        use_a     = 1'b0;
        use_b     = 1'b0;
        is_branch = 1'b0;
        if (valid) begin
            unique case (cls)
                CL_NONE:   begin use_a = 1'b0; use_b = 1'b0; end
                CL_REG2:   begin use_a = 1'b1; use_b = 1'b1; end
                CL_IMM:    begin use_a = 1'b1; use_b = 1'b0; end
                CL_LOAD:   begin use_a = 1'b1; use_b = 1'b0; end
                CL_STORE:  begin use_a = 1'b1; use_b = 1'b1; end
                CL_BRANCH: begin use_a = 1'b1; use_b = 1'b1; is_branch = 1'b1; end
                CL_SHIFT:  begin use_a = 1'b0; use_b = 1'b1; end
                CL_MUL:    begin use_a = 1'b1; use_b = 1'b1; end
                default:   begin use_a = 1'b0; use_b = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/hz_dest_mask.sv
// Module: hz_dest_mask
// Expands one older stage's destination into a one-hot (or two-hot for a
// multiply pair) mask of pending registers. Entry 0 is never pending.
// Assumes NREG == 2**REG_W so that rd+1 wraps naturally.
module hz_dest_mask #(
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             wen,
    input  logic             pair,
    input  logic [REG_W-1:0] rd,
    output logic [NREG-1:0]  mask
);

    logic             writes;
    logic [REG_W-1:0] rd_next;

    // Stage writes the register file at all.
    assign writes  = valid & wen;
    // Second register of a multiply pair, wrapping modulo NREG.
    assign rd_next = rd + REG_W'(1);

    // One mask bit per architectural register.
    for (genvar i = 0; i < NREG; i++) begin : g_bit
        if (i == 0) begin : g_zero
            assign mask[i] = 1'b0;
        end else begin : g_reg
            assign mask[i] = writes &
                             ((rd == REG_W'(i)) | (pair & (rd_next == REG_W'(i))));
        end
    end

    AST_PAIR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) <= 2) else $error("pending mask wider than a pair");  // R5

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && wen) |-> (mask == '0)) else $error("idle stage marks a register");  // R11

endmodule

// File: rtl/hz_branch_ctrl.sv
// Module: hz_branch_ctrl
// Merges the data-hazard flag with branch handling into the pipeline controls.
// Priority: a taken branch in execute wins, then a data hazard, then a branch
// in decode (freeze fetch and discard the slot behind it).
module hz_branch_ctrl
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dep,          // decode source matches a pending register
    input  logic id_branch,    // decode holds a valid branch
    input  logic ex_valid,
    input  logic ex_branch,
    input  logic ex_taken,
    output ctl_t ctl
);

    logic redirect;
    logic hazard;
    logic freeze;

    // Execute resolves a taken branch this cycle.
    assign redirect = ex_valid & ex_branch & ex_taken;
    // Data hazard matters only when the decode slot survives.
    assign hazard   = dep & ~redirect;
    // Branch in decode moves on; fetch freezes behind it.
    assign freeze   = id_branch & ~dep & ~redirect;

    // Control output assembly, gated by reset.
    always_comb begin
        ctl = '0;
        if (rst_n) begin
            ctl.stall       = hazard;
            ctl.pc_hold     = hazard | freeze;
            ctl.ifid_flush  = redirect | freeze;
            ctl.idex_bubble = hazard | redirect;
            ctl.pc_target   = redirect;
        end
    end

    AST_STALL_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.stall |-> (ctl.idex_bubble && ctl.pc_hold)) else $error("stall without bubble");  // R2

    AST_STALL_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.stall |-> !ctl.ifid_flush) else $error("stalled slot flushed");  // R8

    AST_TARGET_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_target |-> (!ctl.pc_hold && ctl.ifid_flush)) else $error("redirect held");  // R9

    AST_NOTTAKEN_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_branch && !ex_taken) |-> !ctl.pc_target) else $error("not-taken redirected");  // R10

endmodule

// File: rtl/hz_ctrl.sv
// Module: hz_ctrl (top)
// Stall/flush controller for a five-stage in-order pipeline without forwarding
// or prediction. Compares decode sources against destinations pending in
// execute and memory; write-back producers never stall because the register
// file writes before it reads. Outputs are combinational from the inputs.
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int NREG  = 32,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [2:0]       id_class,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             ex_valid,
    input  logic             ex_wen,
    input  logic             ex_pair,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_branch,
    input  logic             ex_taken,
    input  logic             mem_valid,
    input  logic             mem_wen,
    input  logic             mem_pair,
    input  logic [REG_W-1:0] mem_rd,
    output logic             stall,
    output logic             pc_hold,
    output logic             ifid_flush,
    output logic             idex_bubble,
    output logic             pc_target
);

    logic            use_a, use_b, id_branch;
    logic [NREG-1:0] ex_mask, mem_mask, pend;
    logic            dep;
    ctl_t            ctl;

    hz_src_decode u_src (
        .valid     (id_valid),
        .cls       (iclass_e'(id_class)),
        .use_a     (use_a),
        .use_b     (use_b),
        .is_branch (id_branch)
    );

    hz_dest_mask #(.NREG(NREG)) u_ex_mask (
        .clk (clk), .rst_n (rst_n),
        .valid (ex_valid), .wen (ex_wen), .pair (ex_pair), .rd (ex_rd),
        .mask (ex_mask)
    );

    hz_dest_mask #(.NREG(NREG)) u_mem_mask (
        .clk (clk), .rst_n (rst_n),
        .valid (mem_valid), .wen (mem_wen), .pair (mem_pair), .rd (mem_rd),
        .mask (mem_mask)
    );

    // Union of registers still to be written by older in-flight instructions.
    assign pend = ex_mask | mem_mask;

    // Read-after-write match on either used source.
    assign dep = (use_a & pend[id_rs]) | (use_b & pend[id_rt]);

    hz_branch_ctrl u_br (
        .clk       (clk),
        .rst_n     (rst_n),
        .dep       (dep),
        .id_branch (id_branch),
        .ex_valid  (ex_valid),
        .ex_branch (ex_branch),
        .ex_taken  (ex_taken),
        .ctl       (ctl)
    );

    // Flatten the control bundle onto the ports.
    assign stall       = ctl.stall;
    assign pc_hold     = ctl.pc_hold;
    assign ifid_flush  = ctl.ifid_flush;
    assign idex_bubble = ctl.idex_bubble;
    assign pc_target   = ctl.pc_target;

    AST_STALL_NEEDS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((ex_valid && ex_wen) || (mem_valid && mem_wen)))
        else $error("stall with no producer");  // R3

    AST_STALL_NEEDS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> id_valid) else $error("stall on empty decode");  // R6

endmodule

// File: tb/sim_hz_ctrl.sv
// Bench: drives decode/execute/memory fields each cycle and compares all
// five controls against a behavioural reference model.
module sim_hz_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 0, ex_valid = 0, ex_wen = 0, ex_pair = 0;
    logic       ex_branch = 0, ex_taken = 0, mem_valid = 0, mem_wen = 0, mem_pair = 0;
    logic [2:0] id_class = 0;
    logic [4:0] id_rs = 0, id_rt = 0, ex_rd = 0, mem_rd = 0;
    logic       stall, pc_hold, ifid_flush, idex_bubble, pc_target;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #10 clk = ~clk;  // 50 MHz

    hz_ctrl u0 (
        .clk, .rst_n, .id_valid, .id_class, .id_rs, .id_rt,
        .ex_valid, .ex_wen, .ex_pair, .ex_rd, .ex_branch, .ex_taken,
        .mem_valid, .mem_wen, .mem_pair, .mem_rd,
        .stall, .pc_hold, .ifid_flush, .idex_bubble, .pc_target
    );

    // Reference: is register r pending from a producer?
    function automatic bit pending(int r, bit v, bit w, bit p, int rd);
        if (r == 0 || !v || !w) return 0;
        if (r == rd) return 1;
        if (p && r == ((rd + 1) % 32)) return 1;
        return 0;
    endfunction

    // Reference: expected {stall,pc_hold,ifid_flush,idex_bubble,pc_target}.
    function automatic logic [4:0] model();
        bit ua, ub, br, dep, redir, hz, frz;
        int c = int'(id_class);
        ua = id_valid && (c == 1 || c == 2 || c == 3 || c == 4 || c == 5 || c == 7);
        ub = id_valid && (c == 1 || c == 4 || c == 5 || c == 6 || c == 7);
        br = id_valid && c == 5;
        dep = (ua && (pending(id_rs, ex_valid, ex_wen, ex_pair, ex_rd) ||
                      pending(id_rs, mem_valid, mem_wen, mem_pair, mem_rd))) ||
              (ub && (pending(id_rt, ex_valid, ex_wen, ex_pair, ex_rd) ||
                      pending(id_rt, mem_valid, mem_wen, mem_pair, mem_rd)));
        redir = ex_valid && ex_branch && ex_taken;
        hz  = dep && !redir;
        frz = br && !dep && !redir;
        if (!rst_n) return 5'b0;
        return {hz, hz || frz, redir || frz, hz || redir, redir};
    endfunction

    function automatic string auto_tag();
        logic [4:0] e = model();
        if (!rst_n) return "R1";
        if (e[0]) return "R9";
        if (ex_valid && ex_branch) return "R10";
        if (e[4] && id_class == 3'd5) return "R8";
        if (e[4]) return "R2";
        if (e[2]) return "R7";
        return "R3";
    endfunction

    // Compare every clock, away from the active edge.
    task automatic check(string tag);
        logic [4:0] act, exp;
        @(negedge clk);
        act = {stall, pc_hold, ifid_flush, idex_bubble, pc_target};
        exp = model();
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: controls actual=%b expected=%b (id c%0d rs%0d rt%0d ex rd%0d p%0b mem rd%0d p%0b)",
                     tag, act, exp, id_class, id_rs, id_rt, ex_rd, ex_pair, mem_rd, mem_pair);
        end
    endtask

    task automatic clear();
        id_valid = 0; id_class = 0; id_rs = 0; id_rt = 0;
        ex_valid = 0; ex_wen = 0; ex_pair = 0; ex_rd = 0; ex_branch = 0; ex_taken = 0;
        mem_valid = 0; mem_wen = 0; mem_pair = 0; mem_rd = 0;
    endtask

    task automatic set_id(int c, int rs, int rt);
        id_valid = 1; id_class = 3'(c); id_rs = 5'(rs); id_rt = 5'(rt);
    endtask

    task automatic set_ex(bit w, bit p, int rd);
        ex_valid = 1; ex_wen = w; ex_pair = p; ex_rd = 5'(rd);
    endtask

    task automatic set_mem(bit w, bit p, int rd);
        mem_valid = 1; mem_wen = w; mem_pair = p; mem_rd = 5'(rd);
    endtask

    // Step: wait past the edge, then apply the case set up by the caller.
    task automatic step();
        @(posedge clk); #2;
    endtask

    initial begin
        // R1: reset holds controls low even with a hazard present.
        clear(); set_id(1, 5, 6); set_ex(1, 0, 5);
        check("R1"); check("R1");
        step(); rst_n = 1;
        check("R2");  // same hazard now stalls (R2)

        step(); clear(); set_id(1, 4, 7); set_mem(1, 0, 7); check("R2");
        step(); clear(); set_id(1, 5, 6); set_ex(1, 0, 9); check("R3");
        step(); clear(); set_id(1, 5, 6); check("R3");
        step(); clear(); set_id(1, 0, 0); set_ex(1, 0, 0); check("R4");
        step(); clear(); set_id(2, 0, 3); set_ex(1, 1, 31); check("R4");
        step(); clear(); set_id(1, 9, 2); set_ex(1, 1, 8); check("R5");
        step(); clear(); set_id(1, 2, 9); set_mem(1, 1, 8); check("R5");
        step(); clear(); set_id(2, 31, 0); set_ex(1, 1, 31); check("R5");
        step(); clear(); set_id(1, 10, 10); set_ex(1, 1, 8); check("R5");
        step(); clear(); set_id(2, 3, 5); set_ex(1, 0, 5); check("R6");
        step(); clear(); set_id(6, 5, 3); set_ex(1, 0, 5); check("R6");
        step(); clear(); set_id(6, 3, 5); set_ex(1, 0, 5); check("R6");
        step(); clear(); set_id(4, 3, 5); set_mem(1, 0, 5); check("R6");
        step(); clear(); set_id(3, 3, 5); set_mem(1, 0, 5); check("R6");
        step(); clear(); set_id(0, 5, 5); set_ex(1, 0, 5); check("R6");
        step(); clear(); set_id(5, 1, 2); set_ex(1, 0, 9); check("R7");
        step(); clear(); set_id(5, 1, 2); set_mem(1, 0, 2); check("R8");
        step(); clear(); set_id(1, 4, 4); set_ex(0, 0, 0); ex_branch = 1; ex_taken = 1;
        set_mem(1, 0, 4); check("R9");
        step(); clear(); set_ex(0, 0, 0); ex_branch = 1; check("R10");
        step(); clear(); set_id(1, 4, 4); set_ex(0, 0, 0); ex_branch = 1;
        set_mem(1, 0, 4); check("R10");
        step(); clear(); set_id(1, 6, 6); ex_rd = 6; ex_wen = 1; check("R11");
        step(); clear(); set_id(1, 6, 6); set_ex(0, 0, 6); set_mem(0, 1, 5); check("R11");

        // Pseudo-random stream; small register range makes matches frequent.
        for (int i = 0; i < 3000; i++) begin
            step();
            id_valid  = $urandom_range(0, 3) != 0;
            id_class  = 3'($urandom_range(0, 7));
            id_rs     = 5'($urandom_range(0, 7));
            id_rt     = 5'($urandom_range(0, 7));
            ex_valid  = $urandom_range(0, 3) != 0;
            ex_wen    = $urandom_range(0, 1);
            ex_pair   = $urandom_range(0, 3) == 0;
            ex_rd     = ($urandom_range(0, 9) == 0) ? 5'd31 : 5'($urandom_range(0, 7));
            ex_branch = $urandom_range(0, 5) == 0;
            ex_taken  = $urandom_range(0, 1);
            mem_valid = $urandom_range(0, 3) != 0;
            mem_wen   = $urandom_range(0, 1);
            mem_pair  = $urandom_range(0, 3) == 0;
            mem_rd    = 5'($urandom_range(0, 7));
            if (i % 500 == 250) rst_n = 0;
            else rst_n = 1;
            check(auto_tag());
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule